// File: doc/BRIEF.md
# Microcontroller Parallel Port Unit

This block holds the four 8-bit general-purpose ports of a small microcontroller core. Each port owns a bank of eight storage bits that the CPU writes through a byte-wide strobe. The CPU reads a port in one of two ways: from the stored bits, or from the levels actually present on the pads. Pads are modelled as separate input, output and output-enable vectors. A pad that is not enabled floats to a weak pull-up, so a stored 1 can be pulled low by an outside load.

Port 1 and port 3 share their pads with peripheral outputs. The peripheral value reaches a pad only while the stored bit is 1. The pad levels of these ports are also passed back out as peripheral inputs.

A bus sequencer outside the block can take over port 0 and port 2 for external memory. Port 0 carries the low address byte and then the data byte on the same pads. Port 2 carries the high address byte when the access uses a wide address. Every cycle of such an access loads all ones into the port 0 storage. The port 2 storage is left as it is.

Top module: `mcu_port_unit`

## Requirements
- R1: While reset is active, and after it, until the first write, every port stores 0xFF, every `pad_oe` bit is 0 and every `pad_out` bit is 1. Reset is asserted asynchronously and released two clock edges after `rst_n` rises.
- R2: When `cpu_wr_en` is 1 at a clock edge, the port numbered by `cpu_wr_sel` stores `cpu_wr_data` from that edge on. The other ports keep their values. Without a write, a port keeps its value, except as stated in R10.
- R3: `rd_latch_data` shows the stored byte of the port numbered by `cpu_rd_sel`. `rd_pin_data` shows that port's pad levels. The two differ when an outside load pulls a released pad low.
- R4: Port 0 outside a bus access, and port 2 outside a wide bus access, drive `pad_out` equal to the stored byte and `pad_oe` equal to its inverse. Port n, bit b sits at pad index 8*n+b.
- R5: On ports 1 and 3, the drive value v is the stored byte AND the matching alternate output byte. `pad_out` equals v and `pad_oe` equals ~v, so a stored 0 always holds the pad low.
- R6: `alt_in_p1` and `alt_in_p3` always equal the pad input levels of ports 1 and 3.
- R7: When `xbus_en` is 1 and `xbus_addr_ph` is 1, port 0 drives `xbus_addr[7:0]` with all eight enables set.
- R8: When `xbus_en` is 1 and `xbus_addr_ph` is 0, port 0 behaves by direction. If `xbus_wr` is 1, it drives `xbus_wdata` with all enables set. If `xbus_wr` is 0, it drives 0 with all enables cleared. `xbus_rdata` always equals the port 0 pad input levels.
- R9: When `xbus_en` and `xbus_wide` are both 1, port 2 drives `xbus_addr[15:8]` with all enables set.
- R10: At each clock edge where `xbus_en` is 1, the port 0 storage becomes 0xFF, even if a CPU write to port 0 is present at the same edge. The port 2 storage does not change because of a bus access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr_en | input | 1 | Store strobe for the selected port |
| cpu_wr_sel | input | 2 | Port number to store into |
| cpu_wr_data | input | 8 | Byte to store |
| cpu_rd_sel | input | 2 | Port number for both readbacks |
| rd_latch_data | output | 8 | Stored byte of the selected port |
| rd_pin_data | output | 8 | Pad levels of the selected port |
| pad_in | input | 32 | Pad input levels, port n bit b at 8*n+b |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| alt_out_p1 | input | 8 | Peripheral outputs for port 1 |
| alt_out_p3 | input | 8 | Peripheral outputs for port 3 |
| alt_in_p1 | output | 8 | Port 1 pad levels to peripherals |
| alt_in_p3 | output | 8 | Port 3 pad levels to peripherals |
| xbus_en | input | 1 | External memory access in progress |
| xbus_addr_ph | input | 1 | 1 = address phase, 0 = data phase |
| xbus_wr | input | 1 | 1 = write access, 0 = read access |
| xbus_wide | input | 1 | Access uses a 16-bit address |
| xbus_addr | input | 16 | Access address |
| xbus_wdata | input | 8 | Write data for the data phase |
| xbus_rdata | output | 8 | Read data taken from port 0 pads |

## Verification
The bench pulls single pads low while their stored bit is 1. A design that routed one readback through the other would return equal bytes where they must differ. It writes port 0 in the same cycle as a bus access, and a design with the wrong priority would keep the CPU byte instead of 0xFF. Narrow accesses are checked so that port 2 keeps its own byte, not the high address. Alternate outputs are driven high over stored zeros, and a design without the gate would release the pad.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  typedef enum logic [1:0] {
    KIND_ADDR_DATA,
    KIND_ALT,
    KIND_ADDR_HI,
    KIND_PLAIN
  } port_kind_e;

  function automatic port_kind_e kind_of(input int idx);
    case (idx)
      0:       return KIND_ADDR_DATA;
      1, 3:    return KIND_ALT;
      2:       return KIND_ADDR_HI;
      default: return KIND_PLAIN;
    endcase
  endfunction
endpackage

// File: rtl/mpu_rst_sync.sv
module mpu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/mpu_port_latch.sv
module mpu_port_latch #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             force_ones,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (force_ones)  q_nxt = '1;
    else if (we)     q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '1;
    else        q <= q_nxt;
  end

  AST_FORCE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    force_ones |=> (q == '1)); // R10
  AST_LOAD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !force_ones) |=> (q == $past(d))); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && !force_ones) |=> $stable(q)); // R2
endmodule

// File: rtl/mpu_rd_mux.sv
module mpu_rd_mux #(
  parameter int WIDTH = 8,
  parameter int NPORT = 4,
  localparam int SEL_W = $clog2(NPORT)
) (
  input  logic [NPORT*WIDTH-1:0] latch_flat,
  input  logic [NPORT*WIDTH-1:0] pin_flat,
  input  logic [SEL_W-1:0]       sel,
  output logic [WIDTH-1:0]       latch_rd,
  output logic [WIDTH-1:0]       pin_rd
);
  always_comb begin
    latch_rd = latch_flat[sel*WIDTH +: WIDTH];
    pin_rd   = pin_flat[sel*WIDTH +: WIDTH];
  end
endmodule

// File: rtl/mcu_port_unit.sv
module mcu_port_unit
  import mpu_pkg::*;
#(
  parameter int PORT_W    = 8,
  parameter int NUM_PORTS = 4,
  localparam int SEL_W    = $clog2(NUM_PORTS),
  localparam int PAD_W    = NUM_PORTS * PORT_W,
  localparam int ADDR_W   = 2 * PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr_en,
  input  logic [SEL_W-1:0]  cpu_wr_sel,
  input  logic [PORT_W-1:0] cpu_wr_data,
  input  logic [SEL_W-1:0]  cpu_rd_sel,
  output logic [PORT_W-1:0] rd_latch_data,
  output logic [PORT_W-1:0] rd_pin_data,
  input  logic [PAD_W-1:0]  pad_in,
  output logic [PAD_W-1:0]  pad_out,
  output logic [PAD_W-1:0]  pad_oe,
  input  logic [PORT_W-1:0] alt_out_p1,
  input  logic [PORT_W-1:0] alt_out_p3,
  output logic [PORT_W-1:0] alt_in_p1,
  output logic [PORT_W-1:0] alt_in_p3,
  input  logic              xbus_en,
  input  logic              xbus_addr_ph,
  input  logic              xbus_wr,
  input  logic              xbus_wide,
  input  logic [ADDR_W-1:0] xbus_addr,
  input  logic [PORT_W-1:0] xbus_wdata,
  output logic [PORT_W-1:0] xbus_rdata
);
  logic              rst_sync_n;
  logic [PORT_W-1:0] latch_q [NUM_PORTS];
  logic [PORT_W-1:0] drv_out [NUM_PORTS];
  logic [PORT_W-1:0] drv_oe  [NUM_PORTS];
  logic [PAD_W-1:0]  latch_flat;
  logic              bus_hi;

  assign bus_hi = xbus_en & xbus_wide;

  mpu_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    localparam port_kind_e KIND = kind_of(g);
    logic wr_hit;
    logic force_hit;

    assign wr_hit    = cpu_wr_en && (cpu_wr_sel == SEL_W'(g));
    assign force_hit = (KIND == KIND_ADDR_DATA) && xbus_en;

    mpu_port_latch #(.WIDTH(PORT_W)) u_latch (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .we         (wr_hit),
      .force_ones (force_hit),
      .d          (cpu_wr_data),
      .q          (latch_q[g])
    );

    if (KIND == KIND_ADDR_DATA) begin : g_ad
      assign drv_out[g] = !xbus_en     ? latch_q[g]            :
                          xbus_addr_ph ? xbus_addr[PORT_W-1:0] :
                          xbus_wr      ? xbus_wdata            : '0;
      assign drv_oe[g]  = !xbus_en     ? ~latch_q[g]           :
                          (xbus_addr_ph || xbus_wr) ? '1       : '0;
    end else if (KIND == KIND_ADDR_HI) begin : g_hi
      assign drv_out[g] = bus_hi ? xbus_addr[ADDR_W-1:PORT_W] : latch_q[g];
      assign drv_oe[g]  = bus_hi ? '1                         : ~latch_q[g];
    end else if (KIND == KIND_ALT) begin : g_alt
      logic [PORT_W-1:0] gated;
      assign gated      = latch_q[g] & ((g == 1) ? alt_out_p1 : alt_out_p3);
      assign drv_out[g] = gated;
      assign drv_oe[g]  = ~gated;
    end else begin : g_plain
      assign drv_out[g] = latch_q[g];
      assign drv_oe[g]  = ~latch_q[g];
    end

    assign pad_out[g*PORT_W +: PORT_W]    = drv_out[g];
    assign pad_oe[g*PORT_W +: PORT_W]     = drv_oe[g];
    assign latch_flat[g*PORT_W +: PORT_W] = latch_q[g];
  end

  mpu_rd_mux #(.WIDTH(PORT_W), .NPORT(NUM_PORTS)) u_rd_mux (
    .latch_flat (latch_flat),
    .pin_flat   (pad_in),
    .sel        (cpu_rd_sel),
    .latch_rd   (rd_latch_data),
    .pin_rd     (rd_pin_data)
  );

  assign alt_in_p1  = pad_in[2*PORT_W-1:PORT_W];
  assign alt_in_p3  = pad_in[4*PORT_W-1:3*PORT_W];
  assign xbus_rdata = pad_in[PORT_W-1:0];

  AST_ALT_GATE_P1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((pad_out[2*PORT_W-1:PORT_W] & ~latch_q[1]) == '0)); // R5
  AST_ALT_GATE_P3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((pad_out[4*PORT_W-1:3*PORT_W] & ~latch_q[3]) == '0)); // R5
  AST_BUS_RD_RELEASE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (xbus_en && !xbus_addr_ph && !xbus_wr) |-> (pad_oe[PORT_W-1:0] == '0)); // R8
  AST_BUS_ADDR_LO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (xbus_en && xbus_addr_ph) |-> (pad_out[PORT_W-1:0] == xbus_addr[PORT_W-1:0])); // R7
  AST_P2_NARROW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bus_hi |-> (pad_out[3*PORT_W-1:2*PORT_W] == latch_q[2])); // R9
  AST_P2_KEPT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (xbus_en && !(cpu_wr_en && cpu_wr_sel == SEL_W'(2))) |=> $stable(latch_q[2])); // R10
endmodule

// File: tb/mcu_port_unit_tb_top.sv
`timescale 1ns/1ps
module mcu_port_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_wr_en;
  logic [1:0]  cpu_wr_sel;
  logic [7:0]  cpu_wr_data;
  logic [1:0]  cpu_rd_sel;
  logic [7:0]  rd_latch_data, rd_pin_data;
  logic [31:0] pad_in, pad_out, pad_oe;
  logic [7:0]  alt_out_p1, alt_out_p3, alt_in_p1, alt_in_p3;
  logic        xbus_en, xbus_addr_ph, xbus_wr, xbus_wide;
  logic [15:0] xbus_addr;
  logic [7:0]  xbus_wdata, xbus_rdata;
  logic [31:0] ext_low;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;
  logic [7:0] m_latch [4];

  always #5 clk = ~clk;

  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ~ext_low);

  mcu_port_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_wr_en(cpu_wr_en), .cpu_wr_sel(cpu_wr_sel), .cpu_wr_data(cpu_wr_data),
    .cpu_rd_sel(cpu_rd_sel), .rd_latch_data(rd_latch_data), .rd_pin_data(rd_pin_data),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .alt_out_p1(alt_out_p1), .alt_out_p3(alt_out_p3),
    .alt_in_p1(alt_in_p1), .alt_in_p3(alt_in_p3),
    .xbus_en(xbus_en), .xbus_addr_ph(xbus_addr_ph), .xbus_wr(xbus_wr),
    .xbus_wide(xbus_wide), .xbus_addr(xbus_addr), .xbus_wdata(xbus_wdata),
    .xbus_rdata(xbus_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] e_out(input int p);
    case (p)
      0: return !xbus_en ? m_latch[0] : xbus_addr_ph ? xbus_addr[7:0] :
                xbus_wr ? xbus_wdata : 8'h00;
      1: return m_latch[1] & alt_out_p1;
      2: return (xbus_en && xbus_wide) ? xbus_addr[15:8] : m_latch[2];
      default: return m_latch[3] & alt_out_p3;
    endcase
  endfunction

  function automatic logic [7:0] e_oe(input int p);
    case (p)
      0: return !xbus_en ? ~m_latch[0] : (xbus_addr_ph || xbus_wr) ? 8'hFF : 8'h00;
      1: return ~(m_latch[1] & alt_out_p1);
      2: return (xbus_en && xbus_wide) ? 8'hFF : ~m_latch[2];
      default: return ~(m_latch[3] & alt_out_p3);
    endcase
  endfunction

  function automatic logic [7:0] e_pin(input int p);
    return (e_oe(p) & e_out(p)) | (~e_oe(p) & ~ext_low[p*8 +: 8]);
  endfunction

  function automatic string tag_of(input int p);
    if (p == 0) return !xbus_en ? "R4" : xbus_addr_ph ? "R7" : "R8";
    if (p == 2) return "R9";
    return "R5";
  endfunction

  task automatic check_all();
    for (int p = 0; p < 4; p++) begin
      chk(tag_of(p), {24'h0, pad_out[p*8 +: 8]}, {24'h0, e_out(p)});
      chk(tag_of(p), {24'h0, pad_oe[p*8 +: 8]},  {24'h0, e_oe(p)});
    end
    chk("R2", {24'h0, rd_latch_data}, {24'h0, m_latch[cpu_rd_sel]});
    chk("R3", {24'h0, rd_pin_data},   {24'h0, e_pin(int'(cpu_rd_sel))});
    chk("R6", {16'h0, alt_in_p3, alt_in_p1}, {16'h0, e_pin(3), e_pin(1)});
    chk("R8", {24'h0, xbus_rdata}, {24'h0, e_pin(0)});
  endtask

  // Check at negedge+1, then advance across one rising edge and update the model.
  task automatic tick();
    #1;
    check_all();
    @(posedge clk);
    if (xbus_en) m_latch[0] = 8'hFF;
    else if (cpu_wr_en && cpu_wr_sel == 2'd0) m_latch[0] = cpu_wr_data;
    for (int p = 1; p < 4; p++)
      if (cpu_wr_en && cpu_wr_sel == 2'(p)) m_latch[p] = cpu_wr_data;
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    cpu_wr_en = 0; cpu_wr_sel = 0; cpu_wr_data = 0; cpu_rd_sel = 0;
    alt_out_p1 = 8'hFF; alt_out_p3 = 8'hFF; ext_low = 0;
    xbus_en = 0; xbus_addr_ph = 0; xbus_wr = 0; xbus_wide = 0;
    xbus_addr = 0; xbus_wdata = 0;
  endtask

  task automatic wr(input logic [1:0] p, input logic [7:0] d);
    cpu_wr_en = 1; cpu_wr_sel = p; cpu_wr_data = d;
    tick();
    cpu_wr_en = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog act=timeout exp=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle_inputs();
    for (int p = 0; p < 4; p++) m_latch[p] = 8'hFF;
    rst_n = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", pad_out, 32'hFFFF_FFFF);
    chk("R1", pad_oe, 32'h0);
    chk("R1", {24'h0, rd_latch_data}, 32'hFF);
    rst_n = 1;
    repeat (3) tick();
    chk("R1", pad_oe, 32'h0);

    // R3: latched 1 on port 1 bit 3 pulled low from outside
    cpu_rd_sel = 2'd1; ext_low = 32'h0000_0800;
    #1;
    chk("R3", {24'h0, rd_latch_data}, 32'hFF);
    chk("R3", {24'h0, rd_pin_data}, 32'hF7);
    tick();
    ext_low = 0;

    // R5: stored zeros hold pads low although peripheral drives high
    wr(2'd1, 8'h0F);
    wr(2'd3, 8'hA5);
    alt_out_p1 = 8'hFF; alt_out_p3 = 8'h3C;
    #1;
    chk("R5", {24'h0, pad_out[15:8]}, 32'h0F);
    chk("R5", {24'h0, pad_out[31:24]}, 32'h24);
    tick();

    // R2/R4: plain drive of ports 0 and 2
    wr(2'd0, 8'h12);
    wr(2'd2, 8'h5A);
    #1;
    chk("R4", {24'h0, pad_out[7:0]}, 32'h12);
    chk("R4", {24'h0, pad_oe[23:16]}, 32'hA5);
    tick();

    // R7/R9: address phase, wide access
    xbus_en = 1; xbus_addr_ph = 1; xbus_wide = 1; xbus_wr = 1;
    xbus_addr = 16'hBEEF; xbus_wdata = 8'h77;
    #1;
    chk("R7", {24'h0, pad_out[7:0]}, 32'hEF);
    chk("R9", {24'h0, pad_out[23:16]}, 32'hBE);
    tick();
    // R8: write data phase, CPU write to port 0 at the same edge
    xbus_addr_ph = 0;
    cpu_wr_en = 1; cpu_wr_sel = 0; cpu_wr_data = 8'h33;
    #1;
    chk("R8", {24'h0, pad_out[7:0]}, 32'h77);
    tick();
    cpu_wr_en = 0;
    // R8: read data phase, narrow address, external device returns 0x96
    xbus_wr = 0; xbus_wide = 0; ext_low = 32'h0000_0069;
    #1;
    chk("R8", {24'h0, pad_oe[7:0]}, 32'h00);
    chk("R8", {24'h0, xbus_rdata}, 32'h96);
    chk("R9", {24'h0, pad_out[23:16]}, 32'h5A);
    tick();
    xbus_en = 0; ext_low = 0; cpu_rd_sel = 0;
    #1;
    chk("R10", {24'h0, rd_latch_data}, 32'hFF);
    cpu_rd_sel = 2;
    #1;
    chk("R10", {24'h0, rd_latch_data}, 32'h5A);
    tick();

    // Constrained random mix
    for (int i = 0; i < 400; i++) begin
      cpu_wr_en    = ($urandom % 3) == 0;
      cpu_wr_sel   = 2'($urandom);
      cpu_wr_data  = 8'($urandom);
      cpu_rd_sel   = 2'($urandom);
      alt_out_p1   = 8'($urandom);
      alt_out_p3   = 8'($urandom);
      ext_low      = (($urandom % 2) == 0) ? 32'h0 : ($urandom & $urandom);
      xbus_en      = ($urandom % 4) == 0;
      xbus_addr_ph = 1'($urandom);
      xbus_wr      = 1'($urandom);
      xbus_wide    = 1'($urandom);
      xbus_addr    = 16'($urandom);
      xbus_wdata   = 8'($urandom);
      tick();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule